// File: doc/BRIEF.md
# External Multiplexed Memory Bus Controller

This block sequences accesses from a microcontroller core to external program and data memory. The external bus shares one byte-wide port between the low address byte and the data byte. A second, dedicated port carries the high address byte. The core presents one request at a time. A request is either a program fetch with a 16-bit address, a data read or write through a 16-bit pointer, or a data read or write through an 8-bit indirect address. The controller then runs a fixed six-phase sequence on the pins.

In the first phase the address strobe is high and the low address byte is on the shared port, so that an external latch can capture it. In the next phase the address strobe falls. The access strobe is then asserted for two phases and released in the fifth phase. The shared port is released in the sixth phase, and in that phase the controller pulses `done`. Program fetches use their own read strobe. Data reads and data writes each use their own strobe. For a read, the byte on the shared port is sampled at the end of the second strobe phase and returned on `rdata`. For an 8-bit-address data access, the high port keeps showing the port latch value held outside the block.

The split `ad_out`/`ad_oe`/`ad_in` signals stand for the bidirectional shared pad. While `ad_oe` is high the block drives the pad at full strength, so the bus needs no external pullups.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While reset is held and after it is released, `addr_strobe` is 0, all three strobes (`prog_rd_n`, `data_rd_n`, `data_wr_n`) are 1, `ad_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: An accepted request gives exactly one cycle with `addr_strobe` high, in phase 1. During phase 1 `ad_oe` is 1 and `ad_out` equals address bits 7:0. No strobe is low while `addr_strobe` is high. `addr_strobe` is 0 in phase 2.
- R3: With `req_kind` 2'b00 (program fetch), `prog_rd_n` is low in phases 3 and 4, and `data_rd_n` and `data_wr_n` stay high. `req_write` has no effect on a fetch, so a fetch is always a read.
- R4: With `req_kind` 2'b01 (data, 16-bit address) or 2'b10/2'b11 (data, 8-bit address), `data_rd_n` is low in phases 3 and 4 when `req_write` is 0, and `data_wr_n` is low in phases 3 and 4 when `req_write` is 1. At most one strobe is low in any cycle.
- R5: On a data write, `ad_oe` is 1 and `ad_out` equals the write byte from phase 2 through phase 5. The byte is therefore on the port before the write strobe falls and until after it rises.
- R6: On a read, `ad_out` holds address bits 7:0 in phase 2, and `ad_oe` is 0 in phases 3 to 6. The byte on `ad_in` at the end of phase 4 appears on `rdata` in phase 6. For every access kind, `ad_oe` is 0 in phase 6.
- R7: For `req_kind` 2'b00 and 2'b01, `hi_port_out` equals address bits 15:8 in phases 1 to 6.
- R8: For `req_kind` 2'b10 or 2'b11, and whenever the controller is idle, `hi_port_out` follows `hi_port_latch`. In these cases address bits 15:8 have no effect on it.
- R9: `done` is high for exactly one cycle, in phase 6. `req_ready` is 1 only while idle. A request presented while `req_ready` is 0, including in the `done` cycle, is ignored: it neither alters the access in progress nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01 data 16-bit address, 10/11 data 8-bit address |
| req_write | input | 1 | Data write when 1 (ignored for fetch) |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| hi_port_latch | input | 8 | Port latch value for the high port |
| addr_strobe | output | 1 | Address latch enable, active high |
| prog_rd_n | output | 1 | Program memory read strobe, active low |
| data_rd_n | output | 1 | Data memory read strobe, active low |
| data_wr_n | output | 1 | Data memory write strobe, active low |
| ad_out | output | 8 | Shared port output byte |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input byte |
| hi_port_out | output | 8 | High address port |

## Verification
The completion pulse and the arrival of the next request can fall in the same cycle. The controller leaves its last phase at the same edge that would otherwise accept work. To provoke this, the bench raises a second request with different kind, direction, address and data after phase 1 of every other access, and holds it through the `done` cycle. It then judges three things. The running access must keep its own address, data and strobe pattern. The request seen in the `done` cycle must not produce an address strobe in the cycle after the controller returns to idle. Only a request presented while `req_ready` is 1 may start a sequence.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH   = 2'b00,
        KIND_DWIDE   = 2'b01,
        KIND_DNARROW = 2'b10,
        KIND_DSPARE  = 2'b11
    } xkind_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR    = 3'd1,
        ST_HOLD    = 3'd2,
        ST_STROBE  = 3'd3,
        ST_XFER    = 3'd4,
        ST_RELEASE = 3'd5,
        ST_FLOAT   = 3'd6
    } xstate_e;

endpackage

// File: rtl/xmem_req_reg.sv
module xmem_req_reg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  xmem_pkg::xkind_e     kind_in,
    input  logic                 wr_in,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic [DATA_W-1:0]    wdata_in,
    input  logic                 sample,
    input  logic [DATA_W-1:0]    bus_in,
    output xmem_pkg::xkind_e     kind_q,
    output logic                 wr_q,
    output logic [ADDR_W-1:0]    addr_q,
    output logic [DATA_W-1:0]    wdata_q,
    output logic [DATA_W-1:0]    rdata_q
);
    import xmem_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= KIND_FETCH;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (capture) begin
            kind_q  <= kind_in;
            wr_q    <= wr_in;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (sample) begin
            rdata_q <= bus_in;
        end
    end

endmodule

// File: rtl/xmem_seq_fsm.sv
module xmem_seq_fsm (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output xmem_pkg::xstate_e  state,
    output logic               ready,
    output logic               ale,
    output logic               strobe_on,
    output logic               done
);
    import xmem_pkg::*;

    xstate_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    state_d = start ? ST_ADDR : ST_IDLE;
            ST_ADDR:    state_d = ST_HOLD;
            ST_HOLD:    state_d = ST_STROBE;
            ST_STROBE:  state_d = ST_XFER;
            ST_XFER:    state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_FLOAT;
            ST_FLOAT:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // per-state outputs
    always_comb begin
        ready     = 1'b0;
        ale       = 1'b0;
        strobe_on = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:    ready     = 1'b1;
            ST_ADDR:    ale       = 1'b1;
            ST_HOLD:    ;
            ST_STROBE:  strobe_on = 1'b1;
            ST_XFER:    strobe_on = 1'b1;
            ST_RELEASE: ;
            ST_FLOAT:   done      = 1'b1;
            default:    ready     = 1'b0;
        endcase
    end

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [1:0]                req_kind,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      req_ready,
    output logic                      done,
    output logic [DATA_W-1:0]         rdata,
    input  logic [ADDR_W-DATA_W-1:0]  hi_port_latch,
    output logic                      addr_strobe,
    output logic                      prog_rd_n,
    output logic                      data_rd_n,
    output logic                      data_wr_n,
    output logic [DATA_W-1:0]         ad_out,
    output logic                      ad_oe,
    input  logic [DATA_W-1:0]         ad_in,
    output logic [ADDR_W-DATA_W-1:0]  hi_port_out
);
    import xmem_pkg::*;

    localparam int HI_W = ADDR_W - DATA_W;

    xstate_e             state;
    logic                strobe_on;
    logic                capture;
    logic                sample;
    xkind_e              kind_q;
    logic                wr_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                is_fetch;
    logic                wr_eff;
    logic                wide_addr;

    assign capture = req_valid & req_ready;

    xmem_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_valid),
        .state     (state),
        .ready     (req_ready),
        .ale       (addr_strobe),
        .strobe_on (strobe_on),
        .done      (done)
    );

    xmem_req_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .kind_in  (xkind_e'(req_kind)),
        .wr_in    (req_write),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .sample   (sample),
        .bus_in   (ad_in),
        .kind_q   (kind_q),
        .wr_q     (wr_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .rdata_q  (rdata)
    );

    always_comb begin
        is_fetch  = (kind_q == KIND_FETCH);
        wr_eff    = wr_q & ~is_fetch;
        wide_addr = (kind_q == KIND_FETCH) || (kind_q == KIND_DWIDE);
        sample    = (state == ST_XFER) & ~wr_eff;
    end

    // strobe steering: one strobe per access kind
    always_comb begin
        prog_rd_n = ~(strobe_on & is_fetch);
        data_rd_n = ~(strobe_on & ~is_fetch & ~wr_eff);
        data_wr_n = ~(strobe_on & wr_eff);
    end

    // shared port drive
    always_comb begin
        ad_oe  = 1'b0;
        ad_out = '0;
        unique case (state)
            ST_ADDR: begin
                ad_oe  = 1'b1;
                ad_out = addr_q[DATA_W-1:0];
            end
            ST_HOLD: begin
                ad_oe  = 1'b1;
                ad_out = wr_eff ? wdata_q : addr_q[DATA_W-1:0];
            end
            ST_STROBE, ST_XFER, ST_RELEASE: begin
                ad_oe  = wr_eff;
                ad_out = wr_eff ? wdata_q : '0;
            end
            default: begin
                ad_oe  = 1'b0;
                ad_out = '0;
            end
        endcase
    end

    // high port: address byte or port latch
    always_comb begin
        if ((state != ST_IDLE) && wide_addr) begin
            hi_port_out = addr_q[ADDR_W-1:DATA_W];
        end else begin
            hi_port_out = hi_port_latch[HI_W-1:0];
        end
    end

endmodule

// File: rtl/xmem_bus_checker.sv
module xmem_bus_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic addr_strobe,
    input logic prog_rd_n,
    input logic data_rd_n,
    input logic data_wr_n,
    input logic ad_oe
);

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~prog_rd_n, ~data_rd_n, ~data_wr_n}) <= 1);

    a_r2_single_ale: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> (!addr_strobe && !req_ready));

    a_r2_no_strobe_with_ale: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |-> (prog_rd_n && data_rd_n && data_wr_n));

    a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> addr_strobe);

    a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> !addr_strobe);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_rd_n || !data_rd_n) |-> !ad_oe);

    a_r5_data_before_wr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_wr_n) |-> (ad_oe && $past(ad_oe)));

    a_r5_data_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_wr_n) |-> ad_oe);

endmodule

bind xmem_bus_ctrl xmem_bus_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .done        (done),
    .addr_strobe (addr_strobe),
    .prog_rd_n   (prog_rd_n),
    .data_rd_n   (data_rd_n),
    .data_wr_n   (data_wr_n),
    .ad_oe       (ad_oe)
);

// File: tb/tb_xmem_bus_ctrl.sv
module tb_xmem_bus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        done;
    logic [7:0]  rdata;
    logic [7:0]  hi_port_latch = 8'h00;
    logic        addr_strobe;
    logic        prog_rd_n;
    logic        data_rd_n;
    logic        data_wr_n;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in = 8'h00;
    logic [7:0]  hi_port_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xmem_bus_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_kind      (req_kind),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .req_ready     (req_ready),
        .done          (done),
        .rdata         (rdata),
        .hi_port_latch (hi_port_latch),
        .addr_strobe   (addr_strobe),
        .prog_rd_n     (prog_rd_n),
        .data_rd_n     (data_rd_n),
        .data_wr_n     (data_wr_n),
        .ad_out        (ad_out),
        .ad_oe         (ad_oe),
        .ad_in         (ad_in),
        .hi_port_out   (hi_port_out)
    );

    task automatic chk(input string tag, input int ph, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s phase %0d: got %h expected %h", tag, ph, got, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic check_idle(input int ph);
        chk("R1 idle strobes/ale/oe", ph, {28'd0, addr_strobe, prog_rd_n, data_rd_n, data_wr_n}, 32'h7);
        chk("R9 idle ready/done", ph, {30'd0, req_ready, done}, 32'h2);
        chk("R6 idle port released", ph, {31'd0, ad_oe}, 32'h0);
        chk("R8 idle high port", ph, {24'd0, hi_port_out}, {24'd0, hi_port_latch});
    endtask

    task automatic run_access(input logic [1:0] k, input logic w, input logic [15:0] a,
                              input logic [7:0] wd, input logic [7:0] sfr, input bit poke);
        bit fetch = (k == 2'b00);
        bit weff  = w && !fetch;
        bit wide  = (k < 2'd2);
        logic [7:0] rv = mem_byte(a);
        @(negedge clk);
        hi_port_latch = sfr;
        req_valid = 1'b1;
        req_kind  = k;
        req_write = w;
        req_addr  = a;
        req_wdata = wd;
        for (int p = 1; p <= 6; p++) begin
            bit strobe;
            bit oe;
            logic [7:0] exp_ad;
            @(negedge clk);
            strobe = (p == 3) || (p == 4);
            oe = (p == 1) || (p == 2) || (weff && p >= 3 && p <= 5);
            exp_ad = (p == 1) ? a[7:0] : ((p == 2 && !weff) ? a[7:0] : wd);
            chk("R2 address strobe", p, {31'd0, addr_strobe}, {31'd0, (p == 1)});
            chk(fetch ? "R3 fetch strobe" : "R4 data strobes", p,
                {29'd0, prog_rd_n, data_rd_n, data_wr_n},
                {29'd0, !(strobe && fetch), !(strobe && !fetch && !weff), !(strobe && weff)});
            chk(weff ? "R5 write drive enable" : "R6 read port enable", p, {31'd0, ad_oe}, {31'd0, oe});
            if (oe) chk(weff ? "R5 write byte" : "R2 low address", p, {24'd0, ad_out}, {24'd0, exp_ad});
            chk(wide ? "R7 high address" : "R8 port latch", p, {24'd0, hi_port_out},
                {24'd0, (wide ? a[15:8] : sfr)});
            chk("R9 done/ready", p, {30'd0, done, req_ready}, {30'd0, (p == 6), 1'b0});
            if (p == 6 && !weff) chk("R6 read data", p, {24'd0, rdata}, {24'd0, rv});
            // stimulus after sampling
            if (p == 1) begin
                req_valid = poke;
                req_kind  = k ^ 2'b01;
                req_write = ~w;
                req_addr  = ~a;
                req_wdata = ~wd;
            end
            if (p == 2 && !wide) hi_port_latch = ~sfr;
            if (p == 2 && !wide) sfr = ~sfr;
            if (p == 3) ad_in = ~rv;
            if (p == 4) ad_in = rv;
            if (p == 5) ad_in = 8'hA5;
        end
        @(negedge clk);
        check_idle(7);
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            chk("R9 request in done cycle ignored", 8, {31'd0, addr_strobe}, 32'd0);
            check_idle(8);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] addrs [6];
        addrs[0] = 16'h0000; addrs[1] = 16'hFFFF; addrs[2] = 16'h12A5;
        addrs[3] = 16'h8001; addrs[4] = 16'h7F80; addrs[5] = 16'hC33C;
        repeat (2) @(negedge clk);
        check_idle(0);   // R1 under reset
        rst_n = 1'b1;
        @(negedge clk);
        check_idle(0);   // R1 after release
        for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < 2; w++) begin
                for (int i = 0; i < 6; i++) begin
                    if (k == 3 && i > 1) continue;
                    run_access(k[1:0], w[0], addrs[i],
                               addrs[i][7:0] ^ 8'h96 ^ 8'(k * 16 + i),
                               8'(8'h5A + i * 17 + k), (i % 2) == 1);
                end
            end
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule